// File: doc/BRIEF.md
# ADC Parallel Bus Interface Sequencer

This block is the digital face of a two-channel, 10-bit sampling converter as a microprocessor sees it. The host talks to it with an active-low chip select and active-low read and write strobes over a 10-bit data port. The port is split into an input path, an output path and an output enable, and the pads make the tri-state. A write stores the bus word in a control register and launches a conversion sequence. One bit of that word chooses between a single conversion and a pair of conversions whose two channels are sampled together.

The strobes and data are brought into the clock domain through a two-stage synchronizer. The sequencer then runs an acquisition phase and one or two conversion phases, and holds a busy flag high throughout. The busy flag falls at the end of the sequence, which the host can take as an interrupt. Each channel's sample value arrives on a plain input port and is stored in its result register when its conversion finishes. Reads are steered to result register 1 or 2 by a pointer. The pointer alternates only in paired mode. A read or write that arrives while a conversion is running aborts the sequence and raises an invalid-data flag.

Top module: `adc_bus_seq`

## Requirements
- R1: While cs_n is high, db_oe is 0 whatever rd_n and wr_n do; db_oe is 1 exactly while cs_n and rd_n are both low.
- R2: A write (cs_n and wr_n low) stores db_i in the control register and raises busy within 3 clock edges of the falling wr_n; busy is high before wr_n rises again.
- R3: When control bit 6 is 0 (single mode), every read returns result register 1 on db_o.
- R4: When control bit 6 is 1 (paired mode), successive reads return result register 1, then register 2, then register 1, and so on, starting with register 1.
- R5: In single mode busy falls on the 22nd rising clock edge after wr_n rises: 3 for synchronizing, 5 for acquisition, 14 for conversion. Result register 1 then holds ch1_sample.
- R6: In paired mode busy falls on the 36th rising edge after wr_n rises. Result register 1 holds ch1_sample and result register 2 holds ch2_sample.
- R7: A read that starts during acquisition or conversion stops the sequence: busy drops, data_bad goes to 1 and both result registers keep their earlier values.
- R8: A write that starts during acquisition or conversion sets data_bad to 1 and keeps busy high. A fresh sequence then runs with the newly written mode, timed from the new rising edge of wr_n.
- R9: A write, an aborting read and a finished sequence each return the read pointer to register 1.
- R10: data_bad returns to 0 when a sequence finishes without interruption.
- R11: After reset busy and data_bad are 0, both result registers read 0 and db_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| db_i | input | 10 | Data bus value driven by the host |
| db_o | output | 10 | Data bus value driven by the block |
| db_oe | output | 1 | Enable for the block's bus drivers |
| ch1_sample | input | 10 | Channel 1 conversion result |
| ch2_sample | input | 10 | Channel 2 conversion result |
| busy | output | 1 | High while a sequence is pending or running |
| data_bad | output | 1 | Set when a sequence is aborted |

## Verification
On every cycle, the assertions check several invariants. The bus enable stays low while chip select is high. A synchronized write start always leaves busy high, and an aborting read always leaves busy low with data_bad set. Busy falls only on a sequence end or a read abort. The phase counters stay in range, the two result loads never coincide, and the read pointer never leaves register 1 in single mode. Other properties need whole scenarios with known sample values, so only the bench shows them. These are the exact 22- and 36-edge busy lengths, which register each read returns as the pointer alternates, results left untouched by a read abort, and the restart of timing after a write abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_ACQ   = 3'd2,
        ST_CONV1 = 3'd3,
        ST_CONV2 = 3'd4
    } seq_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
    parameter int W      = 13,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DW          = 10,
    parameter int ACQ_CYCLES  = 5,
    parameter int CONV_CYCLES = 14,
    parameter int MODE_BIT    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic [DW-1:0] db_s,
    output logic          busy_o,
    output logic          bad_o,
    output logic          ptr_o,
    output logic          load1_o,
    output logic          load2_o
);
    localparam int MAXC = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYCLES - 1);
    localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [CW-1:0] cnt;
        logic          mode;
        logic          busy;
        logic          bad;
        logic          ptr;
        logic          rd_ok;
        logic          wa_prev;
        logic          ra_prev;
        logic [DW-1:0] ctrl;
    } regs_t;

    regs_t r_d, r_q;
    logic  wa, ra, wr_start, wr_end, rd_start, rd_end;
    logic  in_conv, rd_abort, seq_done, load1, load2;

    always_comb begin
        r_d      = r_q;
        wa       = !cs_s && !wr_s;
        ra       = !cs_s && !rd_s && wr_s;
        wr_start = wa && !r_q.wa_prev;
        wr_end   = !wa && r_q.wa_prev;
        rd_start = ra && !r_q.ra_prev;
        rd_end   = !ra && r_q.ra_prev;
        in_conv  = (r_q.state == ST_ACQ) || (r_q.state == ST_CONV1) ||
                   (r_q.state == ST_CONV2);
        rd_abort = rd_start && in_conv;
        seq_done = 1'b0;
        load1    = 1'b0;
        load2    = 1'b0;
        r_d.wa_prev = wa;
        r_d.ra_prev = ra;
        if (wa) r_d.ctrl = db_s;

        case (r_q.state)
            ST_ARMED: begin
                if (wr_end) begin
                    r_d.state = ST_ACQ;
                    r_d.cnt   = '0;
                end
            end
            ST_ACQ: begin
                if (r_q.cnt == ACQ_LAST) begin
                    r_d.state = ST_CONV1;
                    r_d.cnt   = '0;
                    r_d.mode  = r_q.ctrl[MODE_BIT];
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_CONV1: begin
                if (r_q.cnt == CONV_LAST) begin
                    load1 = 1'b1;
                    if (r_q.mode) begin
                        r_d.state = ST_CONV2;
                        r_d.cnt   = '0;
                    end else begin
                        seq_done = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_CONV2: begin
                if (r_q.cnt == CONV_LAST) begin
                    load2    = 1'b1;
                    seq_done = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: ;
        endcase

        if (seq_done) begin
            r_d.state = ST_IDLE;
            r_d.busy  = 1'b0;
            r_d.bad   = 1'b0;
            r_d.ptr   = 1'b0;
        end

        if (rd_start) begin
            if (in_conv) begin
                r_d.state = ST_IDLE;
                r_d.busy  = 1'b0;
                r_d.bad   = 1'b1;
                r_d.ptr   = 1'b0;
                r_d.rd_ok = 1'b0;
                load1     = 1'b0;
                load2     = 1'b0;
            end else begin
                r_d.rd_ok = 1'b1;
            end
        end

        if (rd_end && r_q.rd_ok && r_q.ctrl[MODE_BIT]) r_d.ptr = !r_q.ptr;

        if (wr_start) begin
            if (in_conv) r_d.bad = 1'b1;
            r_d.state = ST_ARMED;
            r_d.busy  = 1'b1;
            r_d.ptr   = 1'b0;
            r_d.cnt   = '0;
            load1     = 1'b0;
            load2     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.state   <= ST_IDLE;
            r_q.wa_prev <= 1'b0;
            r_q.ra_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o  = r_q.busy;
    assign bad_o   = r_q.bad;
    assign ptr_o   = r_q.ptr;
    assign load1_o = load1;
    assign load2_o = load2;

    assert_busy_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> r_q.busy);

    assert_read_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_abort |=> (!r_q.busy && r_q.bad));

    assert_busy_fall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.busy) |-> ($past(seq_done) || $past(rd_abort)));

    assert_acq_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACQ) |-> (r_q.cnt <= ACQ_LAST));

    assert_conv_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_CONV1) || (r_q.state == ST_CONV2)) |-> (r_q.cnt <= CONV_LAST));

    assert_ptr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_q.ctrl[MODE_BIT] && !$past(r_q.ctrl[MODE_BIT])) |-> !r_q.ptr);
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port #(
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load1_i,
    input  logic          load2_i,
    input  logic [DW-1:0] ch1_i,
    input  logic [DW-1:0] ch2_i,
    input  logic          ptr_i,
    input  logic          cs_n_i,
    input  logic          rd_n_i,
    output logic [DW-1:0] rd_data_o,
    output logic          oe_o
);
    typedef struct packed {
        logic [DW-1:0] res1;
        logic [DW-1:0] res2;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load1_i) r_d.res1 = ch1_i;
        if (load2_i) r_d.res2 = ch2_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data_o = ptr_i ? r_q.res2 : r_q.res1;
    assign oe_o      = !cs_n_i && !rd_n_i;

    assert_load_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load1_i && load2_i));
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq #(
    parameter int DW          = 10,
    parameter int ACQ_CYCLES  = 5,
    parameter int CONV_CYCLES = 14,
    parameter int MODE_BIT    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [DW-1:0] db_i,
    output logic [DW-1:0] db_o,
    output logic          db_oe,
    input  logic [DW-1:0] ch1_sample,
    input  logic [DW-1:0] ch2_sample,
    output logic          busy,
    output logic          data_bad
);
    localparam int SW = DW + 3;

    logic [SW-1:0] sync_in, sync_out;
    logic          ptr, load1, load2;

    assign sync_in = {cs_n, rd_n, wr_n, db_i};

    adc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (sync_in),
        .sync_o  (sync_out)
    );

    adc_seq_ctrl #(
        .DW(DW), .ACQ_CYCLES(ACQ_CYCLES), .CONV_CYCLES(CONV_CYCLES), .MODE_BIT(MODE_BIT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (sync_out[DW+2]),
        .rd_s    (sync_out[DW+1]),
        .wr_s    (sync_out[DW]),
        .db_s    (sync_out[DW-1:0]),
        .busy_o  (busy),
        .bad_o   (data_bad),
        .ptr_o   (ptr),
        .load1_o (load1),
        .load2_o (load2)
    );

    adc_result_port #(.DW(DW)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .load1_i   (load1),
        .load2_i   (load2),
        .ch1_i     (ch1_sample),
        .ch2_i     (ch2_sample),
        .ptr_i     (ptr),
        .cs_n_i    (cs_n),
        .rd_n_i    (rd_n),
        .rd_data_o (db_o),
        .oe_o      (db_oe)
    );

    always_comb begin
        if (cs_n === 1'b1) begin
            assert_hiz_when_deselected_R1: assert (db_oe == 1'b0);
        end
    end
endmodule

// File: tb/adc_bus_seq_test.sv
module adc_bus_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [9:0] db_i = '0, ch1 = '0, ch2 = '0;
    logic [9:0] db_o;
    logic       db_oe, busy, data_bad;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [9:0] exp_r1 = '0, exp_r2 = '0;

    always #2 clk = !clk;

    adc_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .db_i(db_i), .db_o(db_o), .db_oe(db_oe),
        .ch1_sample(ch1), .ch2_sample(ch2), .busy(busy), .data_bad(data_bad)
    );

    function automatic int seq_len(input bit paired);
        return 3 + 5 + (paired ? 28 : 14);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Write val; leave wr_n just raised, cs_n and data still held.
    task automatic write_start(input logic [9:0] val);
        @(negedge clk);
        cs_n = 1'b0; db_i = val;
        @(negedge clk);
        wr_n = 1'b0;
        ticks(4);
        chk("R2 busy during write", busy, 1);
        wr_n = 1'b1;
    endtask

    // Count rising edges from wr_n rise until busy is seen low.
    task automatic wait_done(output int n);
        n = 0;
        while (n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 3) cs_n = 1'b1;
            if (!busy) break;
        end
    endtask

    task automatic read_bus(output logic [9:0] v);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0;
        ticks(2);
        v = db_o;
        chk("R1 oe during read", db_oe, 1);
        ticks(2);
        rd_n = 1'b1; cs_n = 1'b1;
        ticks(5);
    endtask

    task automatic check_reads(input bit paired, input int nreads);
        logic [9:0] v;
        for (int k = 0; k < nreads; k++) begin
            read_bus(v);
            if (paired) chk((k % 2) ? "R4 read reg2" : "R4 read reg1", v, (k % 2) ? exp_r2 : exp_r1);
            else        chk("R3 single read reg1", v, exp_r1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        logic [9:0] v, w;
        bit paired;
        void'($urandom(32'h5eed_1234));
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 data_bad", data_bad, 0);
        chk("R11 oe", db_oe, 0);
        read_bus(v);
        chk("R11 reg1 zero", v, 0);

        // R1: strobes with cs_n high
        @(negedge clk);
        rd_n = 1'b0;
        ticks(1);
        chk("R1 hiz with rd low", db_oe, 0);
        wr_n = 1'b0;
        ticks(1);
        chk("R1 hiz with both low", db_oe, 0);
        rd_n = 1'b1; wr_n = 1'b1;
        ticks(4);
        chk("R1 no start when deselected", busy, 0);

        // Directed and random sequences
        for (int it = 0; it < 12; it++) begin
            paired = (it < 2) ? it[0] : $urandom_range(0, 1);
            ch1 = 10'($urandom); ch2 = 10'($urandom);
            v = 10'($urandom);
            v[6] = paired;
            write_start(v);
            wait_done(n);
            chk(paired ? "R6 paired busy length" : "R5 single busy length", n, seq_len(paired));
            exp_r1 = ch1;
            if (paired) exp_r2 = ch2;
            ticks(2);
            chk("R10 data_bad clear", data_bad, 0);
            check_reads(paired, $urandom_range(1, 4));
        end

        // R9: odd number of paired reads, then a new write resets pointer
        ch1 = 10'h155; ch2 = 10'h2aa;
        write_start(10'h040);
        wait_done(n);
        exp_r1 = ch1; exp_r2 = ch2;
        check_reads(1, 1);
        write_start(10'h040);
        wait_done(n);
        read_bus(v);
        chk("R9 pointer reset by write and completion", v, exp_r1);

        // R7: read during conversion aborts, results keep old values
        ch1 = 10'h3c3; ch2 = 10'h0f0;
        write_start(10'h040);
        ticks(12);
        cs_n = 1'b0; rd_n = 1'b0;
        ticks(4);
        rd_n = 1'b1; cs_n = 1'b1;
        ticks(40);
        chk("R7 busy dropped", busy, 0);
        chk("R7 data_bad set", data_bad, 1);
        read_bus(v);
        chk("R7 R9 reg1 unchanged, first read reg1", v, exp_r1);
        read_bus(w);
        chk("R7 reg2 unchanged", w, exp_r2);

        // R8: write during paired conversion restarts as single
        write_start(10'h040);
        ticks(15);
        ch1 = 10'h0a5;
        write_start(10'h000);
        chk("R8 data_bad after write abort", data_bad, 1);
        wait_done(n);
        chk("R8 restart timing single", n, seq_len(0));
        exp_r1 = ch1;
        ticks(2);
        chk("R10 clear after restarted run", data_bad, 0);
        check_reads(0, 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule